// File: doc/BRIEF.md
# Configuration Address Translator

This block sits between a configuration-space requester and the register fabric of a root port. Each request carries a bus number, a device number, a function number, a byte offset and a read/write bit. The block first decides whether the addressed device can exist. It then produces a word-aligned address. Requests to bus 0 resolve inside the root port's own register window. Requests to any other bus resolve inside a configuration window that is reached through one outbound translation region.

For requests that go downstream, the block reprograms that single region. It sets the region's type code, base, limit and retarget value, so that the access reaches the right bus, device and function. Requests that cannot reach a real device are rejected. A rejected read supplies an all-ones data word, which is what an absent function returns. A rejected write is discarded. All results appear on the cycle after the request is sampled.

Top module: `cfg_xlate`

## Requirements
- R1: While reset is high, every output is zero. This includes the region state: enable, type, base, limit and target.
- R2: An accepted request to bus 0 raises acc_valid with acc_local=1 on the next cycle. Its acc_addr equals LOCAL_BASE (default 32'h01FFC000) plus the aligned offset. The region outputs keep their previous values.
- R3: The offset is aligned to a 32-bit word by forcing bits 1:0 to zero before it is added to either window base.
- R4: An accepted request to bus 1 sets the region type to 3'd4, the type-0 configuration code. acc_local is 0 and acc_addr equals CFG_BASE (default 32'h01F00000) plus the aligned offset.
- R5: An accepted request to any bus from 2 to 255 sets the region type to 3'd5, the type-1 configuration code. Any device number 0 to 31 is accepted on these buses.
- R6: On a downstream acceptance, rgn_target equals bus in bits 31:24, device in bits 23:19, function in bits 18:16 and zero in bits 15:0.
- R7: After a downstream acceptance, rgn_enable is 1, rgn_base equals CFG_BASE and rgn_limit equals CFG_BASE plus CFG_SPAN (default 32'h000FC000).
- R8: On bus 0 only devices 0 and 1 exist, and on bus 1 only device 0 exists. A request to any other device on these two buses is rejected, whatever its function number.
- R9: A rejected read raises rej_valid for one cycle with rej_rdata = 32'hFFFFFFFF, and acc_valid stays low.
- R10: A rejected write raises rej_valid for one cycle with rej_rdata = 0. acc_valid stays low and the region outputs keep their previous values.
- R11: A cycle with no request yields acc_valid=0, rej_valid=0, acc_addr=0 and rej_rdata=0 on the next cycle.
- R12: On an accepted request, acc_write repeats the request's write bit. It is 0 whenever acc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled each clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 12 | Byte offset in configuration space |
| acc_valid | output | 1 | Accepted access, one cycle |
| acc_write | output | 1 | Write bit of the accepted access |
| acc_local | output | 1 | 1 = root-port local window, 0 = translated window |
| acc_addr | output | 32 | Resolved word-aligned address |
| rej_valid | output | 1 | Rejected access, one cycle |
| rej_rdata | output | 32 | All-ones fill for a rejected read, else zero |
| rgn_enable | output | 1 | Outbound region enabled |
| rgn_type | output | 3 | Outbound region type code |
| rgn_base | output | 32 | Outbound region base |
| rgn_limit | output | 32 | Outbound region limit |
| rgn_target | output | 32 | Outbound region retarget value |

## Verification
The hardest condition to reach from the ports is a rejected or local access that arrives after the region already holds a downstream target. Only in that situation can a faulty design corrupt live region state without being seen. To reach it, the stimulus first programs the region with a bus-1 access and then with a high-bus access, using distinct function numbers and offsets. It then sends rejected reads and writes and bus-0 accesses, and checks the region outputs against the last accepted downstream request. Back-to-back requests with no idle cycle are mixed in, so that each decision is checked on exactly the cycle after its request.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    // Outbound region type codes
    typedef enum logic [2:0] {
        RT_MEM  = 3'd0,
        RT_IO   = 3'd2,
        RT_CFG0 = 3'd4,
        RT_CFG1 = 3'd5
    } rgn_type_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
    } bdf_t;

    typedef struct packed {
        logic       local_win;
        logic [31:0] addr;
        rgn_type_e  rtype;
        logic [31:0] target;
    } route_t;

    // Retarget word: bus 31:24, device 23:19, function 18:16
    function automatic logic [31:0] pack_target(input bdf_t b);
        return {b.bus, b.dev, b.func, 16'h0000};
    endfunction

    function automatic logic [11:0] word_align(input logic [11:0] o);
        return {o[11:2], 2'b00};
    endfunction

endpackage

// File: rtl/cfg_xlate_filter.sv
module cfg_xlate_filter #(
    parameter int ROOT_DEVS = 2,
    parameter int BUS1_DEVS = 1
) (
    input  logic [7:0] bus,
    input  logic [4:0] dev,
    output logic       present
);
    logic root_ok;
    logic bus1_ok;

    generate
        if (ROOT_DEVS >= 32) begin : g_root_all
            assign root_ok = 1'b1;
        end else begin : g_root_cmp
            assign root_ok = (32'(dev) < ROOT_DEVS);
        end
        if (BUS1_DEVS >= 32) begin : g_bus1_all
            assign bus1_ok = 1'b1;
        end else begin : g_bus1_cmp
            assign bus1_ok = (32'(dev) < BUS1_DEVS);
        end
    endgenerate

    always_comb begin
        if (bus == 8'd0)      present = root_ok;
        else if (bus == 8'd1) present = bus1_ok;
        else                  present = 1'b1;
    end
endmodule

// File: rtl/cfg_xlate_route.sv
module cfg_xlate_route
    import cfg_xlate_pkg::*;
#(
    parameter logic [31:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [31:0] CFG_BASE   = 32'h01F0_0000
) (
    input  bdf_t        bdf,
    input  logic [11:0] off,
    output route_t      route
);
    logic [31:0] aligned;

    assign aligned = {20'd0, word_align(off)};

    always_comb begin
        route.target = pack_target(bdf);
        route.rtype  = (bdf.bus == 8'd1) ? RT_CFG0 : RT_CFG1;
        if (bdf.bus == 8'd0) begin
            route.local_win = 1'b1;
            route.addr      = LOCAL_BASE + aligned;
        end else begin
            route.local_win = 1'b0;
            route.addr      = CFG_BASE + aligned;
        end
    end
endmodule

// File: rtl/cfg_xlate_region.sv
module cfg_xlate_region
    import cfg_xlate_pkg::*;
#(
    parameter logic [31:0] CFG_BASE = 32'h01F0_0000,
    parameter logic [31:0] CFG_SPAN = 32'h000F_C000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  rgn_type_e   type_in,
    input  logic [31:0] target_in,
    output logic        enable,
    output logic [2:0]  rtype,
    output logic [31:0] base,
    output logic [31:0] limit,
    output logic [31:0] target
);
    localparam logic [31:0] CFG_LIMIT = CFG_BASE + CFG_SPAN;

    rgn_type_e type_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            type_q <= RT_MEM;
            base   <= '0;
            limit  <= '0;
            target <= '0;
        end else if (load) begin
            enable <= 1'b1;
            type_q <= type_in;
            base   <= CFG_BASE;
            limit  <= CFG_LIMIT;
            target <= target_in;
        end
    end

    assign rtype = type_q;
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter logic [31:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [31:0] CFG_BASE   = 32'h01F0_0000,
    parameter logic [31:0] CFG_SPAN   = 32'h000F_C000,
    parameter int          ROOT_DEVS  = 2,
    parameter int          BUS1_DEVS  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_func,
    input  logic [11:0] req_off,
    output logic        acc_valid,
    output logic        acc_write,
    output logic        acc_local,
    output logic [31:0] acc_addr,
    output logic        rej_valid,
    output logic [31:0] rej_rdata,
    output logic        rgn_enable,
    output logic [2:0]  rgn_type,
    output logic [31:0] rgn_base,
    output logic [31:0] rgn_limit,
    output logic [31:0] rgn_target
);
    localparam logic [31:0] ALL_ONES = '1;

    bdf_t   bdf;
    route_t route;
    logic   present;
    logic   accept;
    logic   reject;
    logic   rgn_load;

    assign bdf = '{bus: req_bus, dev: req_dev, func: req_func};

    cfg_xlate_filter #(
        .ROOT_DEVS(ROOT_DEVS),
        .BUS1_DEVS(BUS1_DEVS)
    ) u_filter (
        .bus    (req_bus),
        .dev    (req_dev),
        .present(present)
    );

    cfg_xlate_route #(
        .LOCAL_BASE(LOCAL_BASE),
        .CFG_BASE  (CFG_BASE)
    ) u_route (
        .bdf  (bdf),
        .off  (req_off),
        .route(route)
    );

    assign accept   = req_valid && present;
    assign reject   = req_valid && !present;
    assign rgn_load = accept && !route.local_win;

    cfg_xlate_region #(
        .CFG_BASE(CFG_BASE),
        .CFG_SPAN(CFG_SPAN)
    ) u_region (
        .clk      (clk),
        .rst      (rst),
        .load     (rgn_load),
        .type_in  (route.rtype),
        .target_in(route.target),
        .enable   (rgn_enable),
        .rtype    (rgn_type),
        .base     (rgn_base),
        .limit    (rgn_limit),
        .target   (rgn_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            acc_write <= 1'b0;
            acc_local <= 1'b0;
            acc_addr  <= '0;
            rej_valid <= 1'b0;
            rej_rdata <= '0;
        end else begin
            acc_valid <= accept;
            acc_write <= accept && req_write;
            acc_local <= accept && route.local_win;
            acc_addr  <= accept ? route.addr : '0;
            rej_valid <= reject;
            rej_rdata <= (reject && !req_write) ? ALL_ONES : '0;
        end
    end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
    parameter logic [31:0] CFG_BASE  = 32'h01F0_0000,
    parameter logic [31:0] CFG_SPAN  = 32'h000F_C000,
    parameter int          ROOT_DEVS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_bus,
    input logic [4:0]  req_dev,
    input logic        acc_valid,
    input logic        acc_local,
    input logic        rej_valid,
    input logic [31:0] rej_rdata,
    input logic        rgn_enable,
    input logic [2:0]  rgn_type,
    input logic [31:0] rgn_base,
    input logic [31:0] rgn_limit,
    input logic [31:0] rgn_target
);
    // R2
    local_keeps_region_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_local) |-> ($stable(rgn_target) && $stable(rgn_type)));

    // R4
    remote_needs_region_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_local) |-> rgn_enable);

    // R7
    region_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rgn_enable) |-> (rgn_base == CFG_BASE && rgn_limit == CFG_BASE + CFG_SPAN));

    // R8
    root_filter_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus == 8'd0 && 32'(req_dev) >= ROOT_DEVS) |=> (rej_valid && !acc_valid));

    // R9
    reject_read_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_bus == 8'd1 && req_dev != 5'd0) |=> (rej_rdata == 32'hFFFF_FFFF));

    // R10
    reject_keeps_region_chk: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> ($stable(rgn_target) && $stable(rgn_type) && $stable(rgn_enable)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!acc_valid && !rej_valid));
endmodule

bind cfg_xlate cfg_xlate_chk #(
    .CFG_BASE (CFG_BASE),
    .CFG_SPAN (CFG_SPAN),
    .ROOT_DEVS(ROOT_DEVS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bus   (req_bus),
    .req_dev   (req_dev),
    .acc_valid (acc_valid),
    .acc_local (acc_local),
    .rej_valid (rej_valid),
    .rej_rdata (rej_rdata),
    .rgn_enable(rgn_enable),
    .rgn_type  (rgn_type),
    .rgn_base  (rgn_base),
    .rgn_limit (rgn_limit),
    .rgn_target(rgn_target)
);

// File: tb/cfg_xlate_test.sv
module cfg_xlate_test;
    localparam logic [31:0] LBASE = 32'h01FF_C000;
    localparam logic [31:0] CBASE = 32'h01F0_0000;
    localparam logic [31:0] CSPAN = 32'h000F_C000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        req_valid, req_write;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_func;
    logic [11:0] req_off;
    logic        acc_valid, acc_write, acc_local, rej_valid, rgn_enable;
    logic [31:0] acc_addr, rej_rdata, rgn_base, rgn_limit, rgn_target;
    logic [2:0]  rgn_type;

    cfg_xlate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_local(acc_local),
        .acc_addr(acc_addr), .rej_valid(rej_valid), .rej_rdata(rej_rdata),
        .rgn_enable(rgn_enable), .rgn_type(rgn_type), .rgn_base(rgn_base),
        .rgn_limit(rgn_limit), .rgn_target(rgn_target)
    );

    typedef struct {
        string       tag;
        logic        av, aw, al, rv, en;
        logic [31:0] addr, rd, base, lim, tgt;
        logic [2:0]  ty;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Bench-side region state, kept from the requirements
    logic        m_en  = 0;
    logic [2:0]  m_ty  = 0;
    logic [31:0] m_tgt = 0, m_base = 0, m_lim = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [7:0] b, input logic [4:0] d,
                         input logic [2:0] f, input logic [11:0] o, input string tag);
        exp_t e;
        logic ok;
        logic [31:0] al;
        @(negedge clk);
        req_valid = v; req_write = w; req_bus = b; req_dev = d; req_func = f; req_off = o;
        // R8 existence rule
        ok = (b == 0) ? (d < 2) : (b == 1) ? (d == 0) : 1'b1;
        // R3 alignment
        al = {20'd0, o[11:2], 2'b00};
        e.tag = tag;
        e.av = v && ok;
        e.aw = v && ok && w;
        e.al = v && ok && (b == 0);
        e.addr = !(v && ok) ? 32'd0 : (b == 0) ? LBASE + al : CBASE + al;
        e.rv = v && !ok;
        e.rd = (v && !ok && !w) ? 32'hFFFF_FFFF : 32'd0;
        if (v && ok && b != 0) begin
            m_en = 1; m_ty = (b == 1) ? 3'd4 : 3'd5;
            m_tgt = {b, d, f, 16'h0}; m_base = CBASE; m_lim = CBASE + CSPAN;
        end
        e.en = m_en; e.ty = m_ty; e.tgt = m_tgt; e.base = m_base; e.lim = m_lim;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 1'b0, 8'd0, 5'd0, 3'd0, 12'd0, tag);
    endtask

    // Monitor: compares one expected item per cycle after each edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (!rst && q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "acc_valid",  32'(acc_valid),  32'(e.av));
            chk(e.tag, "acc_write",  32'(acc_write),  32'(e.aw));
            chk(e.tag, "acc_local",  32'(acc_local),  32'(e.al));
            chk(e.tag, "acc_addr",   acc_addr,        e.addr);
            chk(e.tag, "rej_valid",  32'(rej_valid),  32'(e.rv));
            chk(e.tag, "rej_rdata",  rej_rdata,       e.rd);
            chk(e.tag, "rgn_enable", 32'(rgn_enable), 32'(e.en));
            chk(e.tag, "rgn_type",   32'(rgn_type),   32'(e.ty));
            chk(e.tag, "rgn_target", rgn_target,      e.tgt);
            chk(e.tag, "rgn_base",   rgn_base,        e.base);
            chk(e.tag, "rgn_limit",  rgn_limit,       e.lim);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0; req_func = 0; req_off = 0;
        // R1 reset state, with a request pending during reset
        @(negedge clk); req_valid = 1; req_bus = 8'd1;
        repeat (2) @(negedge clk);
        chk("R1", "acc_valid",  32'(acc_valid),  0);
        chk("R1", "rej_valid",  32'(rej_valid),  0);
        chk("R1", "acc_addr",   acc_addr,        0);
        chk("R1", "rej_rdata",  rej_rdata,       0);
        chk("R1", "rgn_enable", 32'(rgn_enable), 0);
        chk("R1", "rgn_target", rgn_target,      0);
        chk("R1", "rgn_limit",  rgn_limit,       0);
        req_valid = 0; req_bus = 0;
        rst = 0;

        drive(1, 0, 8'd0,  5'd0,  3'd0, 12'h010, "R2");
        drive(1, 1, 8'd0,  5'd1,  3'd2, 12'h07F, "R3 R12");
        drive(1, 0, 8'd0,  5'd2,  3'd0, 12'h000, "R8 R9");
        idle("R11");
        drive(1, 0, 8'd1,  5'd0,  3'd3, 12'h101, "R4 R6 R7");
        drive(1, 1, 8'd1,  5'd1,  3'd0, 12'h020, "R8 R10");
        drive(1, 0, 8'd0,  5'd31, 3'd7, 12'h004, "R8 R9");
        drive(1, 1, 8'd5,  5'd31, 3'd7, 12'hFFF, "R5 R6 R12");
        drive(1, 0, 8'd0,  5'd1,  3'd0, 12'h0FE, "R2 R3");
        drive(1, 0, 8'd1,  5'd7,  3'd1, 12'h044, "R9 R10");
        idle("R11");
        drive(1, 1, 8'd255, 5'd7, 3'd5, 12'h802, "R5 R6");
        drive(1, 0, 8'd2,  5'd0,  3'd0, 12'h003, "R5 R3");
        drive(1, 1, 8'd0,  5'd5,  3'd1, 12'h010, "R10");
        drive(1, 0, 8'd1,  5'd0,  3'd0, 12'h000, "R4 R7");
        idle("R11");
        idle("R11");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule